// File: doc/BRIEF.md
# MPU region register bank

This block holds the configuration of a memory protection unit with a parameterised number of regions. Each region has three 32-bit entries: a base address, a size/enable word and an access-control word. Software cannot address these entries directly. It first writes a region-number register, and then reaches the selected region's entries through three fixed access windows. The current index chooses which entry sits behind each window.

Accesses arrive as single-cycle requests in coprocessor style. Each request carries a primary register field, a secondary register field, two opcode fields, a write flag, write data and a privilege flag. A write takes effect at the clock edge where its request is present. Read data is combinational, so a read always sees the current index and the current array contents. A write to any window raises a one-cycle flush pulse that tells the translation logic the mappings may have changed. An index write that names a region outside the configured count is discarded and flagged. Unprivileged or unrecognised accesses raise a one-cycle fault.

Top module: `mpu_region_bank`

## Requirements
- R1: After reset every base, size and access entry of every region reads zero, the region number reads zero, and flush_o, fault_o and idx_err_o are low.
- R2: Encoding: crn_i=6 and opc1_i=0 in every case. crm_i=1 with opc2_i=0, 2 or 4 selects the base, size or access window. crm_i=2 with opc2_i=0 selects the region-number register, which reads back the index zero-extended to 32 bits.
- R3: Each window reads and writes the entry of the region selected by the current index. A write lands at the request's clock edge, and read data reflects the current index and contents in the same cycle.
- R4: A region-number write whose value is greater than or equal to NREG is discarded: the index keeps its old value and idx_err_o is high for exactly the following cycle. Values below NREG are accepted.
- R5: flush_o is high for the cycle after each accepted window write. It stays low after reads and after region-number writes.
- R6: A request with priv_i=0 returns zero read data, changes no state, and drives fault_o high for the following cycle.
- R7: A request with any encoding not listed in R2 behaves as in R6: zero read data, no state change, and fault_o high for the following cycle.
- R8: With NREG=0 the windows read zero, window writes change nothing and raise no flush, and every region-number write is rejected as in R4.
- R9: The three arrays are independent. A write through one window leaves the other two windows and the other regions unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request valid |
| we_i | input | 1 | 1 = write, 0 = read |
| priv_i | input | 1 | 1 = privileged level or above |
| crn_i | input | 4 | Primary register number |
| opc1_i | input | 3 | Opcode 1 field |
| crm_i | input | 4 | Secondary register number |
| opc2_i | input | 3 | Opcode 2 field |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Combinational read data |
| flush_o | output | 1 | Mapping-changed pulse |
| fault_o | output | 1 | Access-fault pulse |
| idx_err_o | output | 1 | Rejected index write pulse |

## Verification
A corrupted index shows at once: the very next read of the region-number register returns a different value, and window reads return another region's entries in the same cycle. An array entry that leaks between regions or windows appears only when software reads that region back, so the tests write distinct patterns into several regions and windows, move the index, and read every one. Errors in the pulse outputs show one cycle after the offending request, and the checks sample them there.

// File: rtl/mpu_bank_pkg.sv
package mpu_bank_pkg;
  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_BASE,
    SEL_SIZE,
    SEL_ACC,
    SEL_RNR
  } sel_e;

  localparam logic [3:0] CRN_MPU  = 4'd6;
  localparam logic [3:0] CRM_WIN  = 4'd1;
  localparam logic [3:0] CRM_IDX  = 4'd2;
  localparam int unsigned NWIN    = 3;
  localparam int unsigned DATA_W  = 32;
endpackage

// File: rtl/mpu_reg_decode.sv
module mpu_reg_decode
  import mpu_bank_pkg::*;
(
  input  logic       req_i,
  input  logic       priv_i,
  input  logic [3:0] crn_i,
  input  logic [2:0] opc1_i,
  input  logic [3:0] crm_i,
  input  logic [2:0] opc2_i,
  output sel_e       sel_o,
  output logic       bad_o
);
  sel_e dec;

  always_comb begin
    dec = SEL_NONE;
    if (crn_i == CRN_MPU && opc1_i == 3'd0) begin
      if (crm_i == CRM_WIN) begin
        case (opc2_i)
          3'd0:    dec = SEL_BASE;
          3'd2:    dec = SEL_SIZE;
          3'd4:    dec = SEL_ACC;
          default: dec = SEL_NONE;
        endcase
      end else if (crm_i == CRM_IDX && opc2_i == 3'd0) begin
        dec = SEL_RNR;
      end
    end
  end

  assign bad_o = req_i && (!priv_i || dec == SEL_NONE);
  assign sel_o = (req_i && !bad_o) ? dec : SEL_NONE;
endmodule

// File: rtl/mpu_region_array.sv
module mpu_region_array #(
  parameter int unsigned NREG  = 8,
  parameter int unsigned IDX_W = 3,
  parameter int unsigned DW    = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [DW-1:0]    rdata_o
);
  if (NREG == 0) begin : g_empty
    logic unused_in;
    assign unused_in = ^{clk_i, rst_ni, we_i, idx_i, wdata_i};
    assign rdata_o   = '0;
  end else begin : g_mem
    logic [DW-1:0] mem_q [NREG];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int i = 0; i < NREG; i++) mem_q[i] <= '0;
      end else if (we_i) begin
        mem_q[idx_i] <= wdata_i;
      end
    end

    assign rdata_o = mem_q[idx_i];
  end
endmodule

// File: rtl/mpu_region_bank.sv
module mpu_region_bank
  import mpu_bank_pkg::*;
#(
  parameter int unsigned NREG = 8
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_i,
  input  logic        we_i,
  input  logic        priv_i,
  input  logic [3:0]  crn_i,
  input  logic [2:0]  opc1_i,
  input  logic [3:0]  crm_i,
  input  logic [2:0]  opc2_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  output logic        flush_o,
  output logic        fault_o,
  output logic        idx_err_o
);
  localparam int unsigned IDX_W = (NREG > 1) ? $clog2(NREG) : 1;
  localparam logic [DATA_W-1:0] NREG_W = DATA_W'(NREG);
  localparam bit HAS_REG = (NREG > 0);

  sel_e              sel;
  logic              bad;
  logic              wr;
  logic              idx_ok;
  logic [IDX_W-1:0]  idx_q;
  logic [NWIN-1:0]   win_hit;
  logic [DATA_W-1:0] arr_rd [NWIN];
  logic              flush_q, fault_q, err_q;

  mpu_reg_decode u_dec (
    .req_i  (req_i),
    .priv_i (priv_i),
    .crn_i  (crn_i),
    .opc1_i (opc1_i),
    .crm_i  (crm_i),
    .opc2_i (opc2_i),
    .sel_o  (sel),
    .bad_o  (bad)
  );

  assign wr      = req_i && we_i && !bad;
  assign idx_ok  = wdata_i < NREG_W;
  assign win_hit = {sel == SEL_ACC, sel == SEL_SIZE, sel == SEL_BASE};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                              idx_q <= '0;
    else if (wr && sel == SEL_RNR && idx_ok)  idx_q <= wdata_i[IDX_W-1:0];
  end

  for (genvar k = 0; k < NWIN; k++) begin : g_win
    mpu_region_array #(
      .NREG  (NREG),
      .IDX_W (IDX_W),
      .DW    (DATA_W)
    ) u_arr (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .we_i    (wr && win_hit[k]),
      .idx_i   (idx_q),
      .wdata_i (wdata_i),
      .rdata_o (arr_rd[k])
    );
  end

  always_comb begin
    case (sel)
      SEL_BASE: rdata_o = arr_rd[0];
      SEL_SIZE: rdata_o = arr_rd[1];
      SEL_ACC:  rdata_o = arr_rd[2];
      SEL_RNR:  rdata_o = DATA_W'(idx_q);
      default:  rdata_o = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flush_q <= 1'b0;
      fault_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      flush_q <= HAS_REG && wr && (|win_hit);
      fault_q <= bad;
      err_q   <= wr && sel == SEL_RNR && !idx_ok;
    end
  end

  assign flush_o   = flush_q;
  assign fault_o   = fault_q;
  assign idx_err_o = err_q;
endmodule

// File: rtl/mpu_region_bank_chk.sv
module mpu_region_bank_chk #(
  parameter int unsigned NREG  = 8,
  parameter int unsigned IDX_W = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_i,
  input logic             we_i,
  input logic             priv_i,
  input logic [3:0]       crn_i,
  input logic [2:0]       opc1_i,
  input logic [3:0]       crm_i,
  input logic [2:0]       opc2_i,
  input logic [31:0]      wdata_i,
  input logic [31:0]      rdata_o,
  input logic             flush_o,
  input logic             fault_o,
  input logic             idx_err_o,
  input logic [IDX_W-1:0] idx_q
);
  logic base_ok, rnr_hit, win_hit, priv_req;
  assign base_ok  = crn_i == 4'd6 && opc1_i == 3'd0;
  assign rnr_hit  = base_ok && crm_i == 4'd2 && opc2_i == 3'd0;
  assign win_hit  = base_ok && crm_i == 4'd1 &&
                    (opc2_i == 3'd0 || opc2_i == 3'd2 || opc2_i == 3'd4);
  assign priv_req = req_i && priv_i;

  // R6
  unpriv_fault_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !priv_i) |=> fault_o);

  // R6
  unpriv_rdata_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !priv_i) |-> rdata_o == 32'd0);

  // R4
  idx_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (priv_req && we_i && rnr_hit && wdata_i >= 32'(NREG)) |=> idx_q == $past(idx_q));

  // R4
  idx_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (priv_req && we_i && rnr_hit && wdata_i >= 32'(NREG)) |=> idx_err_o);

  // R5
  flush_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o |-> $past(priv_req && we_i && win_hit));

  // R7
  bad_enc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !rnr_hit && !win_hit) |=> fault_o && !flush_o);
endmodule

bind mpu_region_bank mpu_region_bank_chk #(
  .NREG  (NREG),
  .IDX_W (IDX_W)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .req_i     (req_i),
  .we_i      (we_i),
  .priv_i    (priv_i),
  .crn_i     (crn_i),
  .opc1_i    (opc1_i),
  .crm_i     (crm_i),
  .opc2_i    (opc2_i),
  .wdata_i   (wdata_i),
  .rdata_o   (rdata_o),
  .flush_o   (flush_o),
  .fault_o   (fault_o),
  .idx_err_o (idx_err_o),
  .idx_q     (idx_q)
);

// File: tb/mpu_region_bank_test.sv
module mpu_region_bank_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0, we_i = 1'b0, priv_i = 1'b0;
  logic [3:0]  crn_i = '0, crm_i = '0;
  logic [2:0]  opc1_i = '0, opc2_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o, rdata0;
  logic        flush_o, fault_o, idx_err_o, flush0, fault0, err0;

  int checks = 0, errors = 0;
  logic [31:0] rd;
  logic        fl, ft, er, fl0, er0;
  logic [31:0] rd0;

  always #4 clk_i = ~clk_i;

  mpu_region_bank #(.NREG(8)) uut (
    .clk_i, .rst_ni, .req_i, .we_i, .priv_i, .crn_i, .opc1_i, .crm_i, .opc2_i,
    .wdata_i, .rdata_o, .flush_o, .fault_o, .idx_err_o);

  mpu_region_bank #(.NREG(0)) uut0 (
    .clk_i, .rst_ni, .req_i, .we_i, .priv_i, .crn_i, .opc1_i, .crm_i, .opc2_i,
    .wdata_i, .rdata_o(rdata0), .flush_o(flush0), .fault_o(fault0), .idx_err_o(err0));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // full-control access; called at a negedge, returns at a negedge
  task automatic acc(logic w, logic p, logic [3:0] crn, logic [2:0] o1,
                     logic [3:0] crm, logic [2:0] o2, logic [31:0] d);
    req_i = 1'b1; we_i = w; priv_i = p; crn_i = crn; opc1_i = o1;
    crm_i = crm; opc2_i = o2; wdata_i = d;
    #1 rd = rdata_o; rd0 = rdata0;
    @(posedge clk_i); @(negedge clk_i);
    fl = flush_o; ft = fault_o; er = idx_err_o; fl0 = flush0; er0 = err0;
    req_i = 1'b0; we_i = 1'b0;
  endtask

  // window: 0 base, 1 size, 2 access, 3 region number
  task automatic reg_acc(logic w, int win, logic [31:0] d);
    logic [3:0] crm = (win == 3) ? 4'd2 : 4'd1;
    logic [2:0] o2  = (win == 3) ? 3'd0 : 3'(win * 2);
    acc(w, 1'b1, 4'd6, 3'd0, crm, o2, d);
  endtask

  task automatic t_reset;
    for (int w = 0; w < 4; w++) begin
      reg_acc(1'b0, w, 0);
      chk("R1 read after reset", rd, 0);
    end
    chk("R1 pulses after reset", {29'd0, fl, ft, er}, 0);
  endtask

  task automatic t_rw;
    reg_acc(1'b1, 3, 3);
    chk("R4 accepted idx no err", {31'd0, er}, 0);
    chk("R5 no flush on idx write", {31'd0, fl}, 0);
    reg_acc(1'b0, 3, 0);
    chk("R2 region number readback", rd, 3);
    reg_acc(1'b1, 0, 32'hA000_0000);
    chk("R5 flush after base write", {31'd0, fl}, 1);
    reg_acc(1'b1, 1, 32'h0000_0027);
    reg_acc(1'b1, 2, 32'h0000_0306);
    reg_acc(1'b0, 0, 0); chk("R3 base r3", rd, 32'hA000_0000);
    chk("R5 no flush on read", {31'd0, fl}, 0);
    reg_acc(1'b0, 1, 0); chk("R3 size r3", rd, 32'h0000_0027);
    reg_acc(1'b0, 2, 0); chk("R3 acc r3", rd, 32'h0000_0306);
    reg_acc(1'b1, 3, 5);
    reg_acc(1'b0, 0, 0); chk("R9 base r5 untouched", rd, 0);
    reg_acc(1'b1, 1, 32'h1234_5678);
    reg_acc(1'b0, 0, 0); chk("R9 base r5 after size write", rd, 0);
    reg_acc(1'b0, 1, 0); chk("R3 size r5", rd, 32'h1234_5678);
    reg_acc(1'b1, 3, 3);
    reg_acc(1'b0, 1, 0); chk("R9 size r3 kept", rd, 32'h0000_0027);
  endtask

  task automatic t_idx;
    reg_acc(1'b1, 3, 8);
    chk("R4 err on idx=NREG", {31'd0, er}, 1);
    reg_acc(1'b0, 3, 0); chk("R4 idx kept", rd, 3);
    reg_acc(1'b1, 3, 32'hFFFF_FFFF);
    chk("R4 err on huge idx", {31'd0, er}, 1);
    reg_acc(1'b0, 3, 0); chk("R4 idx kept huge", rd, 3);
    reg_acc(1'b1, 3, 7);
    chk("R4 idx=NREG-1 accepted", {31'd0, er}, 0);
    reg_acc(1'b0, 3, 0); chk("R4 idx=7 readback", rd, 7);
    reg_acc(1'b1, 2, 32'hCAFE_F00D);
    reg_acc(1'b0, 2, 0); chk("R3 acc r7", rd, 32'hCAFE_F00D);
  endtask

  task automatic t_priv;
    acc(1'b1, 1'b0, 4'd6, 3'd0, 4'd1, 3'd4, 32'h1111_1111);
    chk("R6 fault on unpriv write", {31'd0, ft}, 1);
    chk("R6 no flush unpriv", {31'd0, fl}, 0);
    acc(1'b0, 1'b0, 4'd6, 3'd0, 4'd1, 3'd4, 0);
    chk("R6 unpriv read zero", rd, 0);
    acc(1'b1, 1'b0, 4'd6, 3'd0, 4'd2, 3'd0, 1);
    reg_acc(1'b0, 3, 0); chk("R6 idx unchanged", rd, 7);
    chk("R6 fault cleared", {31'd0, ft}, 0);
    reg_acc(1'b0, 2, 0); chk("R6 acc r7 unchanged", rd, 32'hCAFE_F00D);
  endtask

  task automatic t_enc;
    acc(1'b1, 1'b1, 4'd5, 3'd0, 4'd1, 3'd4, 32'h2222_2222);
    chk("R7 fault crn", {31'd0, ft}, 1);
    acc(1'b1, 1'b1, 4'd6, 3'd1, 4'd1, 3'd4, 32'h3333_3333);
    chk("R7 fault opc1", {31'd0, ft}, 1);
    acc(1'b0, 1'b1, 4'd6, 3'd0, 4'd1, 3'd1, 0);
    chk("R7 fault opc2", {31'd0, ft}, 1);
    chk("R7 read zero", rd, 0);
    acc(1'b1, 1'b1, 4'd6, 3'd0, 4'd2, 3'd1, 2);
    chk("R7 fault crm2 opc2", {31'd0, ft}, 1);
    reg_acc(1'b0, 2, 0); chk("R7 acc r7 unchanged", rd, 32'hCAFE_F00D);
    reg_acc(1'b0, 3, 0); chk("R7 idx unchanged", rd, 7);
  endtask

  task automatic t_zero;
    reg_acc(1'b1, 0, 32'h5555_5555);
    chk("R8 no flush zero regions", {31'd0, fl0}, 0);
    reg_acc(1'b0, 0, 0); chk("R8 base reads zero", rd0, 0);
    reg_acc(1'b1, 3, 0);
    chk("R8 idx 0 rejected", {31'd0, er0}, 1);
  endtask

  task automatic t_rereset;
    @(negedge clk_i); rst_ni = 1'b0;
    @(negedge clk_i); rst_ni = 1'b1;
    reg_acc(1'b0, 3, 0); chk("R1 idx zero after reset", rd, 0);
    reg_acc(1'b1, 3, 3);
    reg_acc(1'b0, 0, 0); chk("R1 base r3 cleared", rd, 0);
    reg_acc(1'b1, 3, 7);
    reg_acc(1'b0, 2, 0); chk("R1 acc r7 cleared", rd, 0);
  endtask

  initial begin
    #200000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_rw();
    t_idx();
    t_priv();
    t_enc();
    t_zero();
    t_rereset();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule